// File: doc/BRIEF.md
# Light-Load Burst Sequencer for a Bridge PWM Stage

This block sits between a digital pulse-width modulator and the gate drivers of a bridge power stage. Under normal load it is transparent: both phase signals and all synchronous-rectifier enables pass through unchanged. When it is allowed to act (a bridge topology is flagged and the two-bit power-mode setting is zero) and the sampled output current drops below a programmed entry level, it takes over. It holds every rectifier enable low and passes a fixed number of whole pulses on each of the two phases. It then blanks both phases until the sampled error voltage rises above a programmed threshold, and at that point it lets a fresh burst through.

Burst operation ends when the current climbs back to the entry level plus a programmed hysteresis, or when the block is no longer allowed to act. The block changes between passing, gating and blanking only when both phase inputs are low, so a pulse is never cut short. A two-bit status output shows the operating state. A single-cycle strobe marks every burst start. The thresholds and the burst-length code are captured when each burst begins.

Top module: `lightload_burst_ctrl`

## Requirements
- R1: The block is allowed to act only when `bridge_en` is 1 and `pwr_mode` is 0 (values 1, 2 and 3 disable it). While the status is normal (0), `pwm_a_out`/`pwm_b_out` equal `pwm_a_in`/`pwm_b_in` and `sr_en_out` equals `sr_en_in` in the same cycle. While not allowed, the status stays normal.
- R2: From the normal status, burst operation begins at a clock edge where the block is allowed, `iout_smp < cur_thr` (unsigned) and both phase inputs are low.
- R3: While the status is burst-on (1) or burst-off (2), every bit of `sr_en_out` is 0.
- R4: Each burst passes 2^`burst_code` pulses on each phase (code 0→1, 1→2, 2→4, 3→8). Pulses are counted at rising edges of the phase inputs.
- R5: In burst-off, both PWM outputs are 0. A new burst starts at a clock edge where both phase inputs are low and `verr_smp > err_thr`, compared as signed two's-complement values.
- R6: Every output pulse is a whole input pulse: no pulse is shortened by entering, ending or leaving a burst.
- R7: Burst operation returns to normal at a clock edge where both phase inputs are low and either `iout_smp >= cur_thr + cur_hyst` or the block is no longer allowed. A current between the entry level and the exit level keeps burst operation going.
- R8: `burst_state` encodes normal=0, burst-on=1, burst-off=2 and is 0 after reset. `burst_start` is high for exactly one cycle, the first cycle of each burst-on period.
- R9: `cur_thr`, `cur_hyst`, `err_thr` and `burst_code` are captured when each burst starts. A change made during a burst does not alter that burst's length or the exit or restart decisions before the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bridge_en | input | 1 | Bridge topology in use |
| pwr_mode | input | 2 | Power mode; 0 permits burst operation |
| iout_smp | input | IW | Output-current sample, unsigned |
| verr_smp | input | EW | Error-voltage sample, signed |
| cur_thr | input | IW | Burst entry current level |
| cur_hyst | input | IW | Added to the entry level to form the exit level |
| err_thr | input | EW | Signed error threshold that restarts a burst |
| burst_code | input | 2 | Pulses per burst per phase, as a power of two |
| pwm_a_in | input | 1 | Modulator phase A |
| pwm_b_in | input | 1 | Modulator phase B |
| sr_en_in | input | NSR | Modulator rectifier enables |
| pwm_a_out | output | 1 | Phase A to driver |
| pwm_b_out | output | 1 | Phase B to driver |
| sr_en_out | output | NSR | Rectifier enables to driver |
| burst_state | output | 2 | 0 normal, 1 burst-on, 2 burst-off |
| burst_start | output | 1 | One-cycle strobe at each burst start |

## Verification
The hardest situation to reach is a change of operating state that is requested while a phase pulse is high. A burst abandoned part way through and a code changed during a running burst are close behind. The bench runs a free-running two-phase modulator model and changes the current, error and code inputs at times that fall inside pulses. It then measures the width of every output pulse and, in a scoreboard, the pulse count of every completed burst. An eight-pulse burst is cut off by raising the current after two periods, which shows a clean exit with no burst recorded.

// File: rtl/lburst_pkg.sv
package lburst_pkg;

   typedef enum logic [1:0] {
      ST_NORMAL = 2'd0,
      ST_ON     = 2'd1,
      ST_OFF    = 2'd2
   } bst_t;

   localparam int CNT_W = 4;

   function automatic logic [CNT_W-1:0] code_to_len(input logic [1:0] code);
      return CNT_W'(1) << code;
   endfunction

endpackage

// File: rtl/lburst_phase_gate.sv
module lburst_phase_gate #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ph_in,
   input  logic             active,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic             ph_out,
   output logic             done
);

   logic             prev_q;
   logic             pass_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;
   logic             room;

   assign rise = ph_in & ~prev_q;
   assign room = cnt_q < limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pass_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= ph_in;
         if (clr) begin
            cnt_q  <= '0;
            pass_q <= 1'b0;
         end else if (active) begin
            if (rise) begin
               pass_q <= room;
               if (room) cnt_q <= cnt_q + 1'b1;
            end else if (!ph_in) begin
               pass_q <= 1'b0;
            end
         end else begin
            pass_q <= 1'b0;
         end
      end
   end

   // a pulse is admitted whole at its rising edge, or not at all
   assign ph_out = active & ph_in & (rise ? room : pass_q);
   assign done   = cnt_q >= limit;

endmodule

// File: rtl/lburst_cmp.sv
module lburst_cmp #(
   parameter int IW = 12,
   parameter int EW = 12
) (
   input  logic [IW-1:0]        iout,
   input  logic [IW-1:0]        live_thr,
   input  logic [IW-1:0]        held_thr,
   input  logic [IW-1:0]        held_hyst,
   input  logic signed [EW-1:0] verr,
   input  logic signed [EW-1:0] held_err,
   output logic                 below_entry,
   output logic                 above_exit,
   output logic                 err_high
);

   localparam int XW = IW + 1;

   logic [XW-1:0] exit_lvl;

   assign exit_lvl    = {1'b0, held_thr} + {1'b0, held_hyst};
   assign below_entry = iout < live_thr;
   assign above_exit  = {1'b0, iout} >= exit_lvl;
   assign err_high    = verr > held_err;

endmodule

// File: rtl/lightload_burst_ctrl.sv
module lightload_burst_ctrl
   import lburst_pkg::*;
#(
   parameter int IW  = 12,
   parameter int EW  = 12,
   parameter int NSR = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bridge_en,
   input  logic [1:0]           pwr_mode,
   input  logic [IW-1:0]        iout_smp,
   input  logic signed [EW-1:0] verr_smp,
   input  logic [IW-1:0]        cur_thr,
   input  logic [IW-1:0]        cur_hyst,
   input  logic signed [EW-1:0] err_thr,
   input  logic [1:0]           burst_code,
   input  logic                 pwm_a_in,
   input  logic                 pwm_b_in,
   input  logic [NSR-1:0]       sr_en_in,
   output logic                 pwm_a_out,
   output logic                 pwm_b_out,
   output logic [NSR-1:0]       sr_en_out,
   output logic [1:0]           burst_state,
   output logic                 burst_start
);

   localparam int NPH = 2;

   if (IW < 2 || EW < 2 || NSR < 1) begin : g_bad_params
      $error("lightload_burst_ctrl: IW, EW must be >= 2 and NSR >= 1");
   end

   bst_t                 st_q, st_d;
   logic                 start_evt;
   logic                 start_q;
   logic [IW-1:0]        thr_l, hyst_l;
   logic signed [EW-1:0] err_l;
   logic [1:0]           code_l;
   logic [CNT_W-1:0]     burst_len;

   logic                 enabled, leave, both_low, in_burst;
   logic                 below_entry, above_exit, err_high;
   logic [NPH-1:0]       ph_in, ph_gated, ph_done;

   assign enabled   = bridge_en && (pwr_mode == 2'd0);
   assign ph_in     = {pwm_b_in, pwm_a_in};
   assign both_low  = ~|ph_in;
   assign burst_len = code_to_len(code_l);
   assign leave     = !enabled || above_exit;

   lburst_cmp #(.IW(IW), .EW(EW)) u_cmp (
      .iout        (iout_smp),
      .live_thr    (cur_thr),
      .held_thr    (thr_l),
      .held_hyst   (hyst_l),
      .verr        (verr_smp),
      .held_err    (err_l),
      .below_entry (below_entry),
      .above_exit  (above_exit),
      .err_high    (err_high)
   );

   for (genvar gi = 0; gi < NPH; gi++) begin : g_phase
      lburst_phase_gate #(.CNT_W(CNT_W)) u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .ph_in  (ph_in[gi]),
         .active (st_q == ST_ON),
         .clr    (start_evt),
         .limit  (burst_len),
         .ph_out (ph_gated[gi]),
         .done   (ph_done[gi])
      );
   end

   // every state change waits for a gap in which both phases are low
   always_comb begin
      st_d      = st_q;
      start_evt = 1'b0;
      unique case (st_q)
         ST_NORMAL: begin
            if (enabled && below_entry && both_low) begin
               st_d      = ST_ON;
               start_evt = 1'b1;
            end
         end
         ST_ON: begin
            if (leave && both_low)              st_d = ST_NORMAL;
            else if ((&ph_done) && both_low)    st_d = ST_OFF;
         end
         ST_OFF: begin
            if (leave && both_low) begin
               st_d = ST_NORMAL;
            end else if (err_high && both_low) begin
               st_d      = ST_ON;
               start_evt = 1'b1;
            end
         end
         default: st_d = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_NORMAL;
         start_q <= 1'b0;
         thr_l   <= '0;
         hyst_l  <= '0;
         err_l   <= '0;
         code_l  <= '0;
      end else begin
         st_q    <= st_d;
         start_q <= start_evt;
         if (start_evt) begin
            thr_l  <= cur_thr;
            hyst_l <= cur_hyst;
            err_l  <= err_thr;
            code_l <= burst_code;
         end
      end
   end

   assign in_burst    = (st_q != ST_NORMAL);
   assign pwm_a_out   = in_burst ? ph_gated[0] : pwm_a_in;
   assign pwm_b_out   = in_burst ? ph_gated[1] : pwm_b_in;
   assign sr_en_out   = in_burst ? '0 : sr_en_in;
   assign burst_state = st_q;
   assign burst_start = start_q;

endmodule

// File: rtl/lightload_burst_chk.sv
module lightload_burst_chk #(
   parameter int IW  = 12,
   parameter int NSR = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           bridge_en,
   input logic [1:0]     pwr_mode,
   input logic [IW-1:0]  iout_smp,
   input logic [IW-1:0]  cur_thr,
   input logic           pwm_a_in,
   input logic           pwm_b_in,
   input logic [NSR-1:0] sr_en_in,
   input logic           pwm_a_out,
   input logic           pwm_b_out,
   input logic [NSR-1:0] sr_en_out,
   input logic [1:0]     burst_state,
   input logic           burst_start
);

   assert_normal_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      burst_state == 2'd0 |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in && sr_en_out == sr_en_in));

   assert_stay_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bridge_en && pwr_mode == 2'd0) && burst_state == 2'd0) |=> burst_state == 2'd0);

   assert_entry_cond_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(burst_state) == 2'd0 && burst_state == 2'd1) |->
         $past(iout_smp < cur_thr && bridge_en && pwr_mode == 2'd0 && !pwm_a_in && !pwm_b_in));

   assert_sr_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      burst_state != 2'd0 |-> sr_en_out == '0);

   assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      burst_state == 2'd2 |-> (!pwm_a_out && !pwm_b_out));

   assert_exit_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(burst_state) != 2'd0 && burst_state == 2'd0) |-> $past(!pwm_a_in && !pwm_b_in));

   assert_state_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_state != 2'd3);

   assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_start |=> !burst_start);

   assert_start_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
      burst_start |-> burst_state == 2'd1);

endmodule

bind lightload_burst_ctrl lightload_burst_chk #(.IW(IW), .NSR(NSR)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bridge_en   (bridge_en),
   .pwr_mode    (pwr_mode),
   .iout_smp    (iout_smp),
   .cur_thr     (cur_thr),
   .pwm_a_in    (pwm_a_in),
   .pwm_b_in    (pwm_b_in),
   .sr_en_in    (sr_en_in),
   .pwm_a_out   (pwm_a_out),
   .pwm_b_out   (pwm_b_out),
   .sr_en_out   (sr_en_out),
   .burst_state (burst_state),
   .burst_start (burst_start)
);

// File: tb/lightload_burst_ctrl_tb_top.sv
`timescale 1ns/100ps
module lightload_burst_ctrl_tb_top;

   localparam int IW = 12, EW = 12, NSR = 2;
   localparam int HI = 3, LO = 2, PER = 2 * (HI + LO);

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                 rst_n;
   logic                 bridge_en;
   logic [1:0]           pwr_mode;
   logic [IW-1:0]        iout_smp, cur_thr, cur_hyst;
   logic signed [EW-1:0] verr_smp, err_thr;
   logic [1:0]           burst_code;
   logic                 pwm_a_in, pwm_b_in;
   logic [NSR-1:0]       sr_en_in;
   logic                 pwm_a_out, pwm_b_out, burst_start;
   logic [NSR-1:0]       sr_en_out;
   logic [1:0]           burst_state;

   lightload_burst_ctrl #(.IW(IW), .EW(EW), .NSR(NSR)) dut_i (.*);

   int  checks = 0, errors = 0;
   int  exp_q[$];
   bit  mod_run = 1'b0;
   bit  finished = 1'b0;

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // modulator model: A pulse, gap, B pulse, gap
   initial begin
      pwm_a_in = 1'b0;
      pwm_b_in = 1'b0;
      forever begin
         @(posedge clk);
         if (mod_run) begin
            #1 pwm_a_in = 1'b1;
            repeat (HI) @(posedge clk);
            #1 pwm_a_in = 1'b0;
            repeat (LO) @(posedge clk);
            #1 pwm_b_in = 1'b1;
            repeat (HI) @(posedge clk);
            #1 pwm_b_in = 1'b0;
            repeat (LO - 1) @(posedge clk);
         end
      end
   end

   // monitor / scoreboard
   logic       pa_q = 1'b0, pb_q = 1'b0, bs_q = 1'b0;
   logic [1:0] st_q = 2'd0;
   int         ca = 0, cb = 0, wa = 0, wb = 0;
   always @(negedge clk) begin
      int e;
      if (rst_n && !finished) begin
         if (burst_state == 2'd0)
            check(pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in && sr_en_out == sr_en_in,
                  "R1 passthrough in normal", {pwm_a_out, pwm_b_out}, {pwm_a_in, pwm_b_in});
         else
            check(sr_en_out == '0, "R3 rectifiers forced off", sr_en_out, 0);
         if (burst_state == 2'd2)
            check(!pwm_a_out && !pwm_b_out, "R5 outputs blank in burst-off", {pwm_a_out, pwm_b_out}, 0);
         if (burst_start) begin
            check(!bs_q && burst_state == 2'd1, "R8 start strobe single and in burst-on", burst_state, 1);
            ca = 0;
            cb = 0;
         end
         if (pwm_a_out && !pa_q) ca++;
         if (pwm_b_out && !pb_q) cb++;
         if (pwm_a_out) wa++;
         else if (pa_q) begin
            check(wa == HI, "R6 phase A pulse whole", wa, HI);
            wa = 0;
         end
         if (pwm_b_out) wb++;
         else if (pb_q) begin
            check(wb == HI, "R6 phase B pulse whole", wb, HI);
            wb = 0;
         end
         if (st_q == 2'd1 && burst_state == 2'd2) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected burst", ca, -1);
            else begin
               e = exp_q.pop_front();
               check(ca == e, "R4 phase A pulses per burst", ca, e);
               check(cb == e, "R4 phase B pulses per burst", cb, e);
            end
         end
         pa_q = pwm_a_out;
         pb_q = pwm_b_out;
         bs_q = burst_start;
         st_q = burst_state;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_state(logic [1:0] s, string req);
      int k = 0;
      while (k < 4000 && burst_state != s) begin
         @(negedge clk);
         k++;
      end
      check(burst_state == s, req, burst_state, s);
      tick(1);
   endtask

   // push the expected count, raise the error, drop it once the burst starts
   task automatic fire(int n);
      int k = 0;
      exp_q.push_back(n);
      verr_smp = 12'sd10;
      while (k < 4000) begin
         @(negedge clk);
         if (burst_start) break;
         k++;
      end
      check(burst_start == 1'b1, "R5 error above threshold restarts burst", burst_start, 1);
      tick(1);
      verr_smp = -12'sd10;
   endtask

   initial begin
      rst_n = 1'b0;
      bridge_en = 1'b1;
      pwr_mode = 2'd3;
      iout_smp = 12'd200;
      cur_thr = 12'd100;
      cur_hyst = 12'd20;
      err_thr = 12'sd4;
      verr_smp = -12'sd10;   // below 4 signed, above it unsigned
      burst_code = 2'd0;
      sr_en_in = '1;
      tick(5);
      check(burst_state == 2'd0, "R8 reset status normal", burst_state, 0);
      check(burst_start == 1'b0, "R8 reset strobe low", burst_start, 0);
      check(pwm_a_out == 1'b0 && pwm_b_out == 1'b0, "R1 reset outputs idle", pwm_a_out, 0);
      rst_n = 1'b1;
      mod_run = 1'b1;
      tick(3 * PER);

      // R1: low current, but not permitted
      iout_smp = 12'd50;
      pwr_mode = 2'd0;
      bridge_en = 1'b0;
      tick(3 * PER);
      check(burst_state == 2'd0, "R1 no entry without bridge", burst_state, 0);
      bridge_en = 1'b1;
      pwr_mode = 2'd1;
      tick(2 * PER);
      check(burst_state == 2'd0, "R1 no entry with mode 1", burst_state, 0);

      // R2: entry, one pulse per phase
      exp_q.push_back(1);
      pwr_mode = 2'd0;
      wait_state(2'd1, "R2 entry on low current");
      wait_state(2'd2, "R4 burst of 1 completes");
      check(sr_en_out == '0, "R3 rectifiers off after burst", sr_en_out, 0);
      tick(3 * PER);
      check(burst_state == 2'd2, "R5 signed error below threshold stays off", burst_state, 2);

      // R4: code 1 gives 2
      burst_code = 2'd1;
      fire(2);
      wait_state(2'd2, "R4 burst of 2 completes");

      // R9: code changed during a burst of 4
      burst_code = 2'd2;
      fire(4);
      burst_code = 2'd3;
      wait_state(2'd2, "R9 burst of 4 unaffected by code change");

      // R4: code 3 gives 8
      fire(8);
      wait_state(2'd2, "R4 burst of 8 completes");

      // R7: hysteresis band keeps burst operation
      iout_smp = 12'd110;
      tick(3 * PER);
      check(burst_state == 2'd2, "R7 inside hysteresis stays in burst", burst_state, 2);
      iout_smp = 12'd120;
      wait_state(2'd0, "R7 exit at threshold plus hysteresis");
      tick(2 * PER);

      // R7/R6: abort an eight-pulse burst mid-way
      iout_smp = 12'd50;
      wait_state(2'd1, "R2 re-entry");
      tick(2 * PER + 1);
      iout_smp = 12'd200;
      wait_state(2'd0, "R7 exit during burst");
      tick(2 * PER);

      // R7: disable by mode 3
      burst_code = 2'd0;
      exp_q.push_back(1);
      iout_smp = 12'd50;
      wait_state(2'd2, "R4 burst of 1 before disable");
      pwr_mode = 2'd3;
      wait_state(2'd0, "R7 exit on mode 3");
      tick(2 * PER);

      check(exp_q.size() == 0, "R4 all expected bursts seen", exp_q.size(), 0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule